// File: doc/BRIEF.md
# UART Port Register Front-End

This block is the bus-side register file of one serial port. A host issues 32-bit register reads and writes over a simple valid/ready request channel. The block holds a transmit queue and a receive queue. It exposes a port-enable register, a status word, a receive-occupancy register, and two data windows: one pushes into the transmit queue and one pops from the receive queue.

A minimal 8N1 transmitter empties the transmit queue, and a matching receiver fills the receive queue. Both are paced by a one-cycle baud tick supplied from outside, so the divisor that sets the line rate lives elsewhere.

Only the low seven address bits are decoded. The 0x80-byte register set therefore repeats throughout the port's 64 KiB window. Offsets with no defined register read as zero and ignore writes.

Top module: `uart_regfront`

## Requirements
- R1: Decode uses only `req_addr[6:0]`. An access at any address behaves exactly like one at that address modulo 0x80.
- R2: Offset 0x04 is the port enable. A write stores `wdata[0]`, a read returns it in bit 0 with all other bits zero, and it resets to 0.
- R3: A read of offset 0x28 returns bit 8 = 1 when the transmit queue is not full, and bit 9 = 1 when the port is ready. Ready means the transmit queue is empty and no frame is being shifted. All other bits read 0, so a port after reset reads 0x300.
- R4: A read of offset 0x68 returns the receive-queue occupancy (0 to 32) in bits 5:0. Bits 31:6 read 0.
- R5: A write to offset 0x70 pushes `wdata[7:0]` into a 32-entry transmit queue. A write while the queue is full is dropped.
- R6: Each frame on `txd` is one low start bit, then 8 data bits LSB first, then one high stop bit, with each bit held for one baud-tick interval. The line idles high. Frames leave in push order, and a new frame starts only while the port is enabled.
- R7: The receiver samples `rxd` on baud ticks. A low sample while idle is a start bit, the next 8 samples are data LSB first, and the 9th must be high. A completed byte is pushed into the 32-entry receive queue only if the port is enabled and the queue is not full. Otherwise the byte, or any frame with a low stop bit, is discarded.
- R8: A read of offset 0x78 returns the oldest received byte in bits 7:0, upper bits zero, and removes it. A read of an empty receive queue returns 0 and removes nothing.
- R9: Every offset other than 0x04, 0x28, 0x68, 0x70 and 0x78 reads 0, and writes to it change nothing.
- R10: `req_ready` is always 1. Each accepted read raises `rd_valid` for exactly one cycle, on the cycle after acceptance, with `rd_data`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address within the port window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
Read data is due one cycle after the request is accepted. The bench queues each expected word when it issues the read, and compares it on the falling edge at which `rd_valid` is high. Serial bits change only on a baud-tick edge, so the transmit monitor samples `txd` on the falling edge after each tick. Receive bytes land in the queue on the edge of the stop-bit tick. Every occupancy read is therefore issued after that tick's falling edge, which makes the count it returns already final.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              baud_tick,
  output logic              txd,
  input  logic              rxd
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [6:0] OFS_EN = 7'h04, OFS_STAT = 7'h28, OFS_RXCNT = 7'h68,
                         OFS_TXD = 7'h70, OFS_RXD = 7'h78;

  wire [6:0] ofs = req_addr[6:0];
  wire wr = req_valid && req_write;
  wire rd = req_valid && !req_write;
  assign req_ready = 1'b1;

  logic en;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= 1'b0;
    else if (wr && ofs == OFS_EN) en <= req_wdata[0];

  // transmit queue and shifter
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic [9:0]    tx_sh;
  logic [3:0]    tx_bits;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire tx_push  = wr && ofs == OFS_TXD && !tx_full;
  wire tx_pop   = baud_tick && en && tx_bits == 4'd0 && !tx_empty;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= req_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '1; tx_bits <= '0;
    end else if (tx_pop) begin
      tx_sh <= {1'b1, tx_mem[tx_rp], 1'b0};
      tx_bits <= 4'd10;
    end else if (baud_tick && tx_bits != 4'd0) begin
      tx_sh <= {1'b1, tx_sh[9:1]};
      tx_bits <= tx_bits - 4'd1;
    end

  assign txd = (tx_bits == 4'd0) ? 1'b1 : tx_sh[0];

  // receiver and receive queue
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_sh;
  logic [3:0]    rx_bits;

  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire rx_push  = baud_tick && rx_bits == 4'd1 && rxd && en && !rx_full;
  wire rx_pop   = rd && ofs == OFS_RXD && !rx_empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh <= '0; rx_bits <= '0;
    end else if (baud_tick) begin
      if (rx_bits == 4'd0) begin
        if (!rxd) rx_bits <= 4'd9;
      end else begin
        if (rx_bits != 4'd1) rx_sh <= {rxd, rx_sh[7:1]};
        rx_bits <= rx_bits - 4'd1;
      end
    end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // read path
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_EN:    rd_mux[0] = en;
      OFS_STAT: begin
        rd_mux[8] = !tx_full;
        rd_mux[9] = tx_empty && tx_bits == 4'd0;
      end
      OFS_RXCNT: rd_mux[CW-1:0] = rx_cnt;
      OFS_RXD:   if (!rx_empty) rd_mux[7:0] = rx_mem[rx_rp];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
    end
endmodule

module uart_regfront_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          rd_valid,
  input logic          txd,
  input logic          en,
  input logic [3:0]    tx_bits,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  // R10
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  // R5
  tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  // R7
  rx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  // R6
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bits == 4'd0 |-> txd);
  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bits == 4'd10 |-> !txd);
  // R6
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bits == 4'd1 |-> txd);
  // R6
  no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && tx_bits == 4'd0) |=> tx_bits == 4'd0);
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_uart_regfront.sv
`timescale 1ns/1ps
module tb_uart_regfront;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_ready, rd_valid, txd, rxd = 1;
  logic baud_tick = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;

  uart_regfront dut (.*);

  int bcnt = 0;
  always @(negedge clk) begin
    baud_tick <= (bcnt == 7);
    bcnt <= (bcnt == 7) ? 0 : bcnt + 1;
  end

  int checks = 0, errs = 0;
  logic [31:0] rq[$];
  string rtag[$];
  logic [7:0] txq[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  task automatic bus_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic bus_rd(logic [15:0] a, logic [31:0] exp, string tag);
    rq.push_back(exp); rtag.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_tick;
    @(posedge clk iff baud_tick);
    @(negedge clk);
  endtask

  task automatic send_rx(logic [7:0] b, logic stop);
    rxd = 0; wait_tick;
    for (int i = 0; i < 8; i++) begin rxd = b[i]; wait_tick; end
    rxd = stop; wait_tick;
    rxd = 1;
  endtask

  // response scoreboard, R10
  always @(negedge clk)
    if (rst_n && rd_valid) begin
      if (rq.size() == 0) check("R10 unexpected response", 1, 0);
      else check(rtag.pop_front(), rd_data, rq.pop_front());
    end

  // serial transmit monitor, R6
  initial forever begin
    wait_tick;
    if (rst_n && txd === 1'b0) begin
      logic [7:0] b;
      for (int i = 0; i < 8; i++) begin wait_tick; b[i] = txd; end
      wait_tick;
      check("R6 stop bit", {31'b0, txd}, 1);
      if (txq.size() == 0) check("R6 unexpected frame", {24'b0, b}, 32'hFFFF_FFFF);
      else check("R6 frame data", {24'b0, b}, {24'b0, txq.pop_front()});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    bus_rd(16'h0004, 0, "R2 reset enable");
    bus_rd(16'h0028, 32'h300, "R3 reset status");
    bus_rd(16'h0068, 0, "R4 reset count");

    bus_wr(16'h0010, '1);
    bus_rd(16'h0010, 0, "R9 unknown offset 0x10");
    bus_wr(16'h0040, 32'h1234);
    bus_rd(16'h0040, 0, "R9 unknown offset 0x40");

    bus_wr(16'h3A84, 32'hFFFF_FFFF);
    bus_rd(16'h0004, 1, "R1 enable written via alias");
    bus_rd(16'hFF04, 1, "R1 enable read via alias");
    bus_wr(16'h0004, 0);
    bus_rd(16'h0004, 0, "R2 enable cleared");

    for (int i = 0; i < 33; i++) begin
      bus_wr(16'h0070, 32'hABCD_0000 | 32'((i * 37 + 5) & 8'hFF));
      if (i < 32) txq.push_back(8'((i * 37 + 5) & 8'hFF));
    end
    bus_rd(16'h0028, 32'h000, "R5 full and busy status");
    repeat (30) wait_tick;
    check("R6 line idle while disabled", {31'b0, txd}, 1);

    bus_wr(16'h0004, 1);
    while (txq.size() != 0) wait_tick;
    repeat (3) wait_tick;
    bus_rd(16'h0028, 32'h300, "R3 ready after drain, 33rd write dropped");

    txq.push_back(8'hA5);
    bus_wr(16'h8070, 32'h0000_00A5);
    bus_rd(16'h0028, 32'h100, "R3 busy while sending");
    while (txq.size() != 0) wait_tick;
    repeat (3) wait_tick;

    send_rx(8'h5A, 1);
    bus_rd(16'h0068, 1, "R4 one byte waiting");
    bus_rd(16'h0078, 32'h5A, "R8 pop data");
    bus_rd(16'h0068, 0, "R8 count after pop");
    bus_rd(16'h0078, 0, "R8 empty read returns zero");
    bus_rd(16'h0068, 0, "R8 empty read pops nothing");

    send_rx(8'hC3, 0);
    bus_rd(16'h0068, 0, "R7 low stop bit dropped");

    bus_wr(16'h0004, 0);
    send_rx(8'h11, 1);
    bus_rd(16'h0068, 0, "R7 disabled port discards");
    bus_wr(16'h0004, 1);

    for (int i = 0; i < 33; i++) send_rx(8'((i * 29) ^ 8'h96), 1);
    bus_rd(16'h0068, 32, "R4 full count");
    for (int i = 0; i < 32; i++)
      bus_rd(16'h0078, 32'(8'((i * 29) ^ 8'h96)), "R7 receive order");
    bus_rd(16'h0068, 0, "R7 byte beyond capacity dropped");

    repeat (20) @(negedge clk);
    check("R10 all reads answered", rq.size(), 0);
    check("R6 all frames sent", txq.size(), 0);
    summary;
    $finish;
  end
endmodule